// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This channel sits next to an external 16-bit free-running timer. A 4-bit mode input picks one of two roles. In capture roles the channel watches an asynchronous input pin. On qualifying edges it stores the timer value into a 16-bit capture register and raises a sticky interrupt flag. A qualifying edge is every falling edge, every rising edge, or every 4th or 16th rising edge.

In compare roles the channel compares the timer with a 16-bit reference value. On a match it can toggle, set or clear an output pin, raise the flag alone, or send a one-cycle pulse that resets the timer. Any mode code that names no role switches the channel off and clears all of its state.

Top module: `capcmp_unit`

## Requirements
- R1: Mode codes 0000, 0001, 0011 and 1100 to 1111 mean off. One cycle after an off code is sampled, `cap_val_o` is 0, `flag_o` is 0, `out_pin_o` is 0, `out_en_o` is 0 and `tmr_rst_o` is 0. The edge count is cleared and no capture or match takes effect.
- R2: The capture pin passes through two synchronizing flops. A pin edge set up before clock edge k updates `cap_val_o` and `flag_o` at edge k+2. The value stored is the `timer_i` value present at edge k+2.
- R3: Mode 0100 captures on every falling edge of the pin. Mode 0101 captures on every rising edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Edges are counted from the entry into the mode. Each capture overwrites the register.
- R5: The first cycle a new mode code is sampled clears the edge count. In that cycle no capture and no compare match takes effect.
- R6: `flag_o` stays set until a one-cycle `flag_clr_i` strobe clears it. If an event arrives in the same cycle as the strobe, the flag stays set.
- R7: Compare modes are 0010 and 1000 to 1011. A match fires only on the first cycle that `timer_i` equals `cmp_val_i`, and only once per run of equality. Its effects appear at the clock edge that samples that equality. A match sets `flag_o`.
- R8: Mode 0010 drives the pin low on entry and toggles it on each match.
- R9: Mode 1000 drives the pin low on entry and sets it high on a match. Mode 1001 drives it high on entry and clears it low on a match.
- R10: Mode 1010 only raises the flag on a match. `out_pin_o` does not change and `out_en_o` is 0.
- R11: Mode 1011 emits a one-cycle `tmr_rst_o` pulse on a match, together with the flag. `out_en_o` is 0.
- R12: `out_en_o` is 1 exactly in modes 0010, 1000 and 1001. It follows the mode input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Mode select |
| timer_i | input | 16 | External timer value |
| cmp_val_i | input | 16 | Compare reference |
| cap_pin_i | input | 1 | Asynchronous capture input pin |
| flag_clr_i | input | 1 | One-cycle flag clear strobe |
| cap_val_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky interrupt flag |
| out_pin_o | output | 1 | Compare output pin level |
| out_en_o | output | 1 | 1 when the channel drives the output pin |
| tmr_rst_o | output | 1 | One-cycle timer reset pulse |

## Verification
Capture results are due three clock edges after the pin edge is driven: two synchronizer stages, then the output register. Compare results, mode entry levels and `out_en_o` are due at the first edge that samples the triggering input. The bench drives inputs on falling clock edges and runs a behavioural model at each rising edge. It compares every output at the next falling edge, so each expected value sits in the cycle it is due. A directed check also confirms the three-edge capture delay explicitly.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [3:0] M_TOGGLE   = 4'b0010;
  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_R4   = 4'b0110;
  localparam logic [3:0] M_CAP_R16  = 4'b0111;
  localparam logic [3:0] M_SET_ON   = 4'b1000;
  localparam logic [3:0] M_CLR_ON   = 4'b1001;
  localparam logic [3:0] M_FLAG     = 4'b1010;
  localparam logic [3:0] M_TRIGGER  = 4'b1011;

  function automatic logic is_cap(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_cmp(input logic [3:0] m);
    return (m == M_TOGGLE) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic is_off(input logic [3:0] m);
    return !is_cap(m) && !is_cmp(m);
  endfunction

  function automatic logic drives_pin(input logic [3:0] m);
    return (m == M_TOGGLE) || (m == M_SET_ON) || (m == M_CLR_ON);
  endfunction
endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
  assign fall_o = ~sh[STAGES-1] & sh[STAGES];

  // R2: an edge seen now entered the pin STAGES clocks ago
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(pin_i, STAGES));
endmodule

// File: rtl/capcmp_prescale.sv
module capcmp_prescale #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ev,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt;

  assign fire = ev && !clr && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (ev)    cnt <= fire ? '0 : cnt + 1'b1;
  end

  // R4: the edge count never runs past the selected divide
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    !clr |-> cnt <= limit);
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic [W-1:0] timer,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  logic eq, eq_q;

  assign eq  = (timer == ref_val);
  assign hit = arm && eq && !eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  // R7: one match per run of equality
  a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    mode_i,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] cmp_val_i,
  input  logic          cap_pin_i,
  input  logic          flag_clr_i,
  output logic [TW-1:0] cap_val_o,
  output logic          flag_o,
  output logic          out_pin_o,
  output logic          out_en_o,
  output logic          tmr_rst_o
);
  localparam int PW = $clog2(DIV_HI);

  logic [3:0]    mode_q;
  logic          chg, off, cap_arm, cmp_arm;
  logic          rise, fall, ev, fire, hit;
  logic [PW-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= mode_i;
  end

  assign chg     = (mode_i != mode_q);
  assign off     = is_off(mode_i);
  assign cap_arm = is_cap(mode_i) && !chg;
  assign cmp_arm = is_cmp(mode_i) && !chg;
  assign ev      = (mode_i == M_CAP_FALL) ? fall : rise;
  assign limit   = (mode_i == M_CAP_R16) ? PW'(DIV_HI - 1) :
                   (mode_i == M_CAP_R4)  ? PW'(DIV_LO - 1) : '0;

  capcmp_sync_edge #(.STAGES(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .pin_i(cap_pin_i), .rise_o(rise), .fall_o(fall));

  capcmp_prescale #(.W(PW)) u_pre (
    .clk(clk), .rst(rst), .clr(!cap_arm), .ev(ev), .limit(limit), .fire(fire));

  capcmp_match #(.W(TW)) u_match (
    .clk(clk), .rst(rst), .arm(cmp_arm), .timer(timer_i),
    .ref_val(cmp_val_i), .hit(hit));

  always_ff @(posedge clk) begin
    if (rst || off) begin
      cap_val_o <= '0;
      flag_o    <= 1'b0;
      out_pin_o <= 1'b0;
      out_en_o  <= 1'b0;
      tmr_rst_o <= 1'b0;
    end else begin
      tmr_rst_o <= hit && (mode_i == M_TRIGGER);
      out_en_o  <= drives_pin(mode_i);
      if (fire) cap_val_o <= timer_i;
      if (fire || hit)     flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
      if (chg) out_pin_o <= (mode_i == M_CLR_ON);
      else if (hit) begin
        case (mode_i)
          M_TOGGLE: out_pin_o <= ~out_pin_o;
          M_SET_ON: out_pin_o <= 1'b1;
          M_CLR_ON: out_pin_o <= 1'b0;
          default:  out_pin_o <= out_pin_o;
        endcase
      end
    end
  end

  // R1: off codes quiet every output on the next cycle
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    is_off(mode_i) |=> (!flag_o && !out_en_o && !out_pin_o && !tmr_rst_o && cap_val_o == '0));
  // R11: a timer reset pulse only comes from the trigger mode, with the flag
  a_r11_trig_src: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_o |-> ($past(mode_i) == M_TRIGGER && flag_o));
  // R6: flag holds without a clear strobe
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr_i && !is_off(mode_i)) |=> flag_o);
  // R12: pin drive only in the driving modes
  a_r12_drive_modes: assert property (@(posedge clk) disable iff (rst)
    out_en_o |-> drives_pin($past(mode_i)));
endmodule

// File: tb/sim_capcmp_unit.sv
module sim_capcmp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode = 4'd0;
  logic [15:0] tmr = 16'd0;
  logic [15:0] cmpv = 16'hffff;
  logic        pin = 1'b0;
  logic        clr = 1'b0;
  logic        hold = 1'b1;
  logic [15:0] cap_val;
  logic        flag, opin, oen, trst;
  int          total = 0;
  int          bad = 0;
  bit          go = 0;

  always #5 clk = ~clk;

  capcmp_unit u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .timer_i(tmr), .cmp_val_i(cmpv),
    .cap_pin_i(pin), .flag_clr_i(clr), .cap_val_o(cap_val), .flag_o(flag),
    .out_pin_o(opin), .out_en_o(oen), .tmr_rst_o(trst));

  // external timer: free running, cleared by the special-event pulse
  always @(negedge clk) if (!hold) tmr <= trst ? 16'd0 : tmr + 16'd1;

  // behavioural reference model
  int        mm, mcnt;
  bit        meq, mflag, mpin, men, mtrst;
  int        mcap;
  bit        hist[$];

  always @(posedge clk) begin
    if (rst) begin
      mm = 0; mcnt = 0; meq = 0; mflag = 0; mpin = 0; men = 0; mtrst = 0; mcap = 0;
      hist = '{0, 0, 0};
    end else begin
      int  m, n;
      bit  rs, fl, chg, off, capm, cmpm, hit, fire, eqn, ev;
      m    = mode;
      rs   = hist[1] && !hist[2];
      fl   = !hist[1] && hist[2];
      hist.push_front(pin);
      void'(hist.pop_back());
      capm = (m >= 4 && m <= 7);
      cmpm = (m == 2 || (m >= 8 && m <= 11));
      off  = !capm && !cmpm;
      chg  = (m != mm);
      fire = 0;
      if (off || chg || !capm) mcnt = 0;
      else begin
        ev = (m == 4) ? fl : rs;
        n  = (m == 6) ? 4 : (m == 7) ? 16 : 1;
        if (ev) begin
          mcnt++;
          if (mcnt == n) begin fire = 1; mcnt = 0; end
        end
      end
      eqn = (tmr == cmpv);
      hit = cmpm && !chg && eqn && !meq;
      meq = eqn;
      if (off) begin
        mcap = 0; mflag = 0; mpin = 0; men = 0; mtrst = 0;
      end else begin
        mtrst = hit && (m == 11);
        men   = (m == 2 || m == 8 || m == 9);
        if (fire) mcap = tmr;
        if (fire || hit) mflag = 1;
        else if (clr)    mflag = 0;
        if (chg) mpin = (m == 9);
        else if (hit) begin
          if (m == 2) mpin = !mpin;
          else if (m == 8) mpin = 1;
          else if (m == 9) mpin = 0;
        end
      end
      mm = m;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (go && !rst) begin
    chk("R2 R3 R4 R5 cap_val", cap_val, mcap);
    chk("R6 R7 flag", flag, mflag);
    chk("R8 R9 out_pin", opin, mpin);
    chk("R10 R12 out_en", oen, men);
    chk("R11 tmr_rst", trst, mtrst);
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int cnt, input int hi, input int lo);
    for (int i = 0; i < cnt; i++) begin
      pin = 1'b1; step(hi);
      pin = 1'b0; step(lo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0; hold = 1'b0; go = 1;
    step(1);
    // R1: reset state
    chk("R1 reset", {cap_val, flag, opin, oen, trst}, 32'd0);

    // R2: capture timing, rising mode
    mode = 4'd5; step(3);
    pin = 1'b1;
    step(1); chk("R2 flag before due", flag, 1'b0);
    step(1); chk("R2 flag before due", flag, 1'b0);
    step(1); chk("R2 flag due", flag, 1'b1);
    chk("R2 captured value", cap_val, tmr);
    step(2);
    clr = 1'b1; step(1); clr = 1'b0; step(1);
    chk("R6 flag cleared", flag, 1'b0);
    pulses(4, 3, 3);
    // R6: strobe at the same time as an event
    pin = 1'b1; step(2); clr = 1'b1; step(1); clr = 1'b0; step(1);
    chk("R6 set wins", flag, 1'b1);
    pin = 1'b0; step(3);

    // R3: falling edges
    mode = 4'd4; step(2);
    pulses(5, 2, 4);
    // R4: divide by 4, then switch to 16 mid count (R5)
    mode = 4'd6; step(2);
    pulses(10, 2, 2);
    mode = 4'd7; step(1);
    pulses(34, 2, 2);
    mode = 4'd6; step(1);
    pulses(6, 1, 2);

    // R1: off codes
    mode = 4'd0; step(2);
    chk("R1 off clears", {cap_val, flag, oen}, 32'd0);
    mode = 4'd1; pulses(3, 2, 2);
    chk("R1 reserved off", {cap_val, flag}, 32'd0);
    mode = 4'd3; step(3);

    // R8: toggle
    mode = 4'd2; step(1);
    chk("R12 out_en follows", oen, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cmpv = tmr + 16'd5; step(8);
    end
    // R7: equality held with timer stopped
    hold = 1'b1; cmpv = tmr; step(6);
    chk("R7 once per run", opin, mpin);
    hold = 1'b0; pulses(2, 2, 2);

    // R9: set / clear
    mode = 4'd8; step(1); chk("R9 init low", opin, 1'b0);
    cmpv = tmr + 16'd4; step(7);
    chk("R9 set on match", opin, 1'b1);
    mode = 4'd9; step(1); chk("R9 init high", opin, 1'b1);
    cmpv = tmr + 16'd4; step(7);
    chk("R9 clear on match", opin, 1'b0);

    // R10: flag only
    clr = 1'b1; step(1); clr = 1'b0;
    mode = 4'd10; cmpv = tmr + 16'd4; step(7);
    chk("R10 flag", flag, 1'b1);
    chk("R10 no drive", oen, 1'b0);

    // R11: timer reset
    mode = 4'd11; cmpv = tmr + 16'd4; step(8);
    chk("R11 timer restarted", tmr < 16'd8, 1'b1);
    step(5);

    mode = 4'd12; step(3);
    chk("R1 code 1100 off", {flag, oen, opin}, 32'd0);
    go = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule